// File: doc/BRIEF.md
# User Interrupt Posting Engine

This block carries out one send-user-interrupt command at a time. A command carries an index into a target table. The table's base address, its size and two enable bits come from configuration inputs. The engine first checks that the feature is enabled and that the index is in range. It then reads one 128-bit table entry through a request/response memory port and checks that entry. Next it takes a lock on the memory port, reads the 128-bit posted-interrupt descriptor named by the entry, sets one pending bit and writes the descriptor back.

A notification is sent only when the descriptor was neither suppressed nor already outstanding. In that case the engine also marks it outstanding and, after the write-back has completed, presents a vector and a destination ID on an interrupt-controller port. The destination is the full 32-bit destination field in extended-ID mode. In legacy mode it is an 8-bit ID taken from that field. Every command ends with either a one-cycle completion pulse or a one-cycle fault pulse that carries a fault class.

Top module: `uipi_post_engine`

## Requirements
- R1: If `cfg_feature_en` or `cfg_target_en` is 0, an accepted command ends with `fault` high and `fault_code` = 1 (invalid operation), one cycle after acceptance, with no memory request.
- R2: If `cmd_index` > `cfg_table_size`, the command ends with `fault_code` = 2 (protection) and makes no memory request. An index equal to the size is legal.
- R3: The first memory request is an unlocked read at address `cfg_table_base + cmd_index*16`. A request holds its address and kind steady until `mem_req_ready`.
- R4: The entry is accepted only if bit 0 is 1 and bits 7:1 are all 0. Otherwise the command ends with fault code 2 after that single read. Bits 13:8 of the entry give the pending-bit number and bits 111:64 give the descriptor address.
- R5: The descriptor read and its write-back are both issued with `mem_lock` high. `mem_lock` stays high without a gap from the read request until the write response, or until a fault.
- R6: If descriptor bits 15:2 or 31:24 are non-zero, the command faults with code 2 and drops the lock without issuing a write.
- R7: The written descriptor equals the one read, except that bit 64+n is set, where n is the entry's pending-bit number, and bit 0 may change as R8 says.
- R8: When descriptor bit 1 (suppress) and bit 0 (outstanding) are both 0, bit 0 is written as 1 and exactly one notification follows. In all other cases bit 0 is unchanged and no notification is sent.
- R9: The notification vector is descriptor bits 23:16. When `cfg_x2_mode` is 1 the destination is bits 63:32; otherwise it is bits 47:40, zero-extended.
- R10: `ntf_valid` rises only after the write response and with `mem_lock` low. It holds its vector and destination steady until `ntf_ready`.
- R11: `busy` is high from acceptance until the cycle of the `done` or `fault` pulse. The two pulses never coincide, and `cmd_valid` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken only while idle |
| cmd_index | input | IDX_W | Target-table index |
| cfg_feature_en | input | 1 | Feature enable |
| cfg_target_en | input | 1 | Target-table enable bit |
| cfg_table_base | input | ADDR_W | Target-table base address |
| cfg_table_size | input | IDX_W | Highest legal index |
| cfg_x2_mode | input | 1 | Extended 32-bit destination mode |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle successful completion |
| fault | output | 1 | One-cycle fault |
| fault_code | output | 2 | Fault class when fault is high: 1 invalid operation, 2 protection |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | Request is a write |
| mem_lock | output | 1 | Lock qualifier for descriptor accesses |
| mem_req_addr | output | ADDR_W | Request byte address |
| mem_req_wdata | output | 128 | Write data |
| mem_rsp_valid | input | 1 | Response (read data or write acknowledge) |
| mem_rsp_rdata | input | 128 | Read data |
| ntf_valid | output | 1 | Notification request |
| ntf_ready | input | 1 | Notification acknowledge |
| ntf_vector | output | 8 | Notification vector |
| ntf_dest | output | 32 | Notification destination ID |

## Verification
On every cycle the assertions check the following rules:
- descriptor writes happen only under the lock;
- the lock is released only at a fault, at completion or when a notification is raised;
- notifications appear only after the lock is gone;
- memory and notification requests hold steady while stalled;
- completion and fault are exclusive and end the busy period;
- an invalid-operation fault comes straight from an idle acceptance.

Some behaviour can only be shown by the bench's scenarios, which compare results against a memory model: the entry address arithmetic, the entry and descriptor reserved-bit checks, the exact pending bit set, the suppress and outstanding decision, the legacy versus extended destination, and commands being ignored while busy.

// File: rtl/uipi_pkg.sv
package uipi_pkg;

    localparam int REC_W = 128;
    localparam int PEND_W = 64;
    localparam int UV_W = $clog2(PEND_W);

    localparam int ENT_UV_LO = 8;
    localparam int ENT_PTR_LO = 64;

    localparam int DSC_OUT_BIT = 0;
    localparam int DSC_SUP_BIT = 1;
    localparam int DSC_NV_LO = 16;
    localparam int DSC_DST_LO = 32;
    localparam int DSC_PEND_LO = 64;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ENT_REQ,
        ST_ENT_RSP,
        ST_DSC_REQ,
        ST_DSC_RSP,
        ST_WB_REQ,
        ST_WB_RSP,
        ST_NTF
    } state_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_BADOP = 2'd1,
        FLT_PROT  = 2'd2
    } fault_e;

endpackage

// File: rtl/uipi_entry_check.sv
module uipi_entry_check
    import uipi_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int RSVD_W = 7
) (
    input  logic              valid_bit,
    input  logic [RSVD_W-1:0] rsvd_bits,
    input  logic [UV_W-1:0]   uv_field,
    input  logic [ADDR_W-1:0] ptr_field,
    output logic              entry_ok,
    output logic [UV_W-1:0]   uv,
    output logic [ADDR_W-1:0] dsc_addr
);
    always_comb begin
        entry_ok = valid_bit && (rsvd_bits == '0);
        uv       = uv_field;
        dsc_addr = ptr_field;
    end
endmodule

// File: rtl/uipi_desc_update.sv
module uipi_desc_update
    import uipi_pkg::*;
(
    input  logic [REC_W-1:0] desc_in,
    input  logic [UV_W-1:0]  uv,
    output logic             desc_ok,
    output logic [REC_W-1:0] desc_out,
    output logic             notify
);
    logic [PEND_W-1:0] pend_d;

    always_comb begin
        desc_ok = (desc_in[15:2] == '0) && (desc_in[31:24] == '0);
        notify  = !desc_in[DSC_SUP_BIT] && !desc_in[DSC_OUT_BIT];
        pend_d  = desc_in[DSC_PEND_LO +: PEND_W];
        pend_d[uv] = 1'b1;
        desc_out = desc_in;
        desc_out[DSC_PEND_LO +: PEND_W] = pend_d;
        if (notify) begin
            desc_out[DSC_OUT_BIT] = 1'b1;
        end
    end
endmodule

// File: rtl/uipi_dest_fmt.sv
module uipi_dest_fmt #(
    parameter int DST_W = 32,
    parameter int LEG_LO = 8,
    parameter int LEG_W = 8
) (
    input  logic [7:0]       nv_field,
    input  logic [DST_W-1:0] dst_field,
    input  logic             x2_mode,
    output logic [7:0]       vector,
    output logic [DST_W-1:0] dest
);
    localparam int PAD_W = DST_W - LEG_W;

    logic [DST_W-1:0] legacy_dest;

    generate
        if (PAD_W > 0) begin : g_pad
            assign legacy_dest = {{PAD_W{1'b0}}, dst_field[LEG_LO +: LEG_W]};
        end else begin : g_nopad
            assign legacy_dest = dst_field[LEG_LO +: DST_W];
        end
    endgenerate

    always_comb begin
        vector = nv_field;
        dest   = x2_mode ? dst_field : legacy_dest;
    end
endmodule

// File: rtl/uipi_post_engine.sv
module uipi_post_engine
    import uipi_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int IDX_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [IDX_W-1:0]  cmd_index,
    input  logic              cfg_feature_en,
    input  logic              cfg_target_en,
    input  logic [ADDR_W-1:0] cfg_table_base,
    input  logic [IDX_W-1:0]  cfg_table_size,
    input  logic              cfg_x2_mode,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [1:0]        fault_code,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic              mem_lock,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [REC_W-1:0]  mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [REC_W-1:0]  mem_rsp_rdata,
    output logic              ntf_valid,
    input  logic              ntf_ready,
    output logic [7:0]        ntf_vector,
    output logic [31:0]       ntf_dest
);
    localparam int ENT_SHIFT = 4;

    typedef struct packed {
        state_e             st;
        logic [ADDR_W-1:0]  ent_addr;
        logic [ADDR_W-1:0]  dsc_addr;
        logic [UV_W-1:0]    uv;
        logic [REC_W-1:0]   wdata;
        logic               notify;
        logic [7:0]         vec;
        logic [31:0]        dst;
        logic               done;
        logic               fault;
        fault_e             code;
    } regs_t;

    regs_t r_q, r_d;

    logic              ent_ok;
    logic [UV_W-1:0]   ent_uv;
    logic [ADDR_W-1:0] ent_ptr;
    logic              dsc_ok;
    logic [REC_W-1:0]  dsc_new;
    logic              dsc_notify;
    logic [7:0]        fmt_vec;
    logic [31:0]       fmt_dst;

    uipi_entry_check #(.ADDR_W(ADDR_W), .RSVD_W(7)) u_entry_check (
        .valid_bit (mem_rsp_rdata[0]),
        .rsvd_bits (mem_rsp_rdata[7:1]),
        .uv_field  (mem_rsp_rdata[ENT_UV_LO +: UV_W]),
        .ptr_field (mem_rsp_rdata[ENT_PTR_LO +: ADDR_W]),
        .entry_ok  (ent_ok),
        .uv        (ent_uv),
        .dsc_addr  (ent_ptr)
    );

    uipi_desc_update u_desc_update (
        .desc_in  (mem_rsp_rdata),
        .uv       (r_q.uv),
        .desc_ok  (dsc_ok),
        .desc_out (dsc_new),
        .notify   (dsc_notify)
    );

    uipi_dest_fmt #(.DST_W(32), .LEG_LO(8), .LEG_W(8)) u_dest_fmt (
        .nv_field  (mem_rsp_rdata[DSC_NV_LO +: 8]),
        .dst_field (mem_rsp_rdata[DSC_DST_LO +: 32]),
        .x2_mode   (cfg_x2_mode),
        .vector    (fmt_vec),
        .dest      (fmt_dst)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.fault = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (!(cfg_feature_en && cfg_target_en)) begin
                        r_d.fault = 1'b1;
                        r_d.code  = FLT_BADOP;
                    end else if (cmd_index > cfg_table_size) begin
                        r_d.fault = 1'b1;
                        r_d.code  = FLT_PROT;
                    end else begin
                        r_d.ent_addr = cfg_table_base + (ADDR_W'(cmd_index) << ENT_SHIFT);
                        r_d.st       = ST_ENT_REQ;
                    end
                end
            end
            ST_ENT_REQ: begin
                if (mem_req_ready) r_d.st = ST_ENT_RSP;
            end
            ST_ENT_RSP: begin
                if (mem_rsp_valid) begin
                    if (!ent_ok) begin
                        r_d.fault = 1'b1;
                        r_d.code  = FLT_PROT;
                        r_d.st    = ST_IDLE;
                    end else begin
                        r_d.uv       = ent_uv;
                        r_d.dsc_addr = ent_ptr;
                        r_d.st       = ST_DSC_REQ;
                    end
                end
            end
            ST_DSC_REQ: begin
                if (mem_req_ready) r_d.st = ST_DSC_RSP;
            end
            ST_DSC_RSP: begin
                if (mem_rsp_valid) begin
                    if (!dsc_ok) begin
                        r_d.fault = 1'b1;
                        r_d.code  = FLT_PROT;
                        r_d.st    = ST_IDLE;
                    end else begin
                        r_d.wdata  = dsc_new;
                        r_d.notify = dsc_notify;
                        r_d.vec    = fmt_vec;
                        r_d.dst    = fmt_dst;
                        r_d.st     = ST_WB_REQ;
                    end
                end
            end
            ST_WB_REQ: begin
                if (mem_req_ready) r_d.st = ST_WB_RSP;
            end
            ST_WB_RSP: begin
                if (mem_rsp_valid) begin
                    if (r_q.notify) begin
                        r_d.st = ST_NTF;
                    end else begin
                        r_d.done = 1'b1;
                        r_d.st   = ST_IDLE;
                    end
                end
            end
            ST_NTF: begin
                if (ntf_ready) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, code: FLT_NONE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        busy          = (r_q.st != ST_IDLE);
        done          = r_q.done;
        fault         = r_q.fault;
        fault_code    = r_q.code;
        mem_req_valid = (r_q.st == ST_ENT_REQ) || (r_q.st == ST_DSC_REQ) || (r_q.st == ST_WB_REQ);
        mem_req_write = (r_q.st == ST_WB_REQ);
        mem_lock      = (r_q.st == ST_DSC_REQ) || (r_q.st == ST_DSC_RSP)
                     || (r_q.st == ST_WB_REQ) || (r_q.st == ST_WB_RSP);
        mem_req_addr  = (r_q.st == ST_ENT_REQ) ? r_q.ent_addr : r_q.dsc_addr;
        mem_req_wdata = r_q.wdata;
        ntf_valid     = (r_q.st == ST_NTF);
        ntf_vector    = r_q.vec;
        ntf_dest      = r_q.dst;
    end

    // R1: an invalid-operation fault follows an idle acceptance directly
    assert_badop_direct_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && fault_code == FLT_BADOP) |-> $past(cmd_valid && !busy));

    // R3: stalled memory requests stay put
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

    // R5: every write goes out under the lock
    assert_write_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> mem_lock);

    // R5: lock released only at fault, completion or notification
    assert_lock_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_lock) |-> (fault || done || ntf_valid));

    // R10: notification only once the lock is gone
    assert_ntf_unlocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_valid |-> !mem_lock);

    // R10: notification holds until acknowledged
    assert_ntf_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ntf_valid && !ntf_ready) |=>
            (ntf_valid && $stable(ntf_vector) && $stable(ntf_dest)));

    // R11: completion and fault are exclusive and close the busy period
    assert_end_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));
    assert_end_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |-> !busy);

endmodule

// File: tb/uipi_post_engine_bench.sv
module uipi_post_engine_bench;
    localparam int AW = 48;
    localparam int IW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [IW-1:0] cmd_index = '0;
    logic cfg_feature_en = 1'b1, cfg_target_en = 1'b1, cfg_x2_mode = 1'b0;
    logic [AW-1:0] cfg_table_base = '0;
    logic [IW-1:0] cfg_table_size = '0;
    logic busy, done, fault;
    logic [1:0] fault_code;
    logic mem_req_valid, mem_req_write, mem_lock;
    logic mem_req_ready = 1'b0;
    logic [AW-1:0] mem_req_addr;
    logic [127:0] mem_req_wdata;
    logic mem_rsp_valid = 1'b0;
    logic [127:0] mem_rsp_rdata = '0;
    logic ntf_valid;
    logic ntf_ready = 1'b0;
    logic [7:0] ntf_vector;
    logic [31:0] ntf_dest;

    always #4 clk = ~clk;

    uipi_post_engine #(.ADDR_W(AW), .IDX_W(IW)) u_uipi_post_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_index(cmd_index),
        .cfg_feature_en(cfg_feature_en), .cfg_target_en(cfg_target_en),
        .cfg_table_base(cfg_table_base), .cfg_table_size(cfg_table_size),
        .cfg_x2_mode(cfg_x2_mode), .busy(busy), .done(done), .fault(fault),
        .fault_code(fault_code), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
        .mem_lock(mem_lock), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .ntf_valid(ntf_valid),
        .ntf_ready(ntf_ready), .ntf_vector(ntf_vector), .ntf_dest(ntf_dest)
    );

    int total = 0, bad = 0;
    logic [127:0] mem [logic [AW-1:0]];

    // activity log filled by the responder
    int acc_cnt, unlocked_dsc, ntf_cnt, done_cnt, fault_cnt, wr_rsp_cnt, ntf_early;
    logic [AW-1:0] first_addr;
    logic first_lock, first_write;
    logic [1:0] seen_code;
    logic [7:0] seen_vec;
    logic [31:0] seen_dst;

    // expected values
    int e_code, e_acc;
    bit e_ntf;
    logic [AW-1:0] e_ea, e_da;
    logic [127:0] e_desc;
    logic [7:0] e_vec;
    logic [31:0] e_dst;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] rd(input logic [AW-1:0] a);
        return mem.exists(a) ? mem[a] : 128'd0;
    endfunction

    task automatic predict(input logic [IW-1:0] idx);
        logic [127:0] ent, d;
        int uv;
        e_ntf = 0; e_acc = 0; e_code = 0; e_desc = '0; e_vec = '0; e_dst = '0;
        e_ea = cfg_table_base + ({32'd0, idx} << 4);
        e_da = '0;
        if (!(cfg_feature_en && cfg_target_en)) begin e_code = 1; return; end
        if (idx > cfg_table_size) begin e_code = 2; return; end
        ent = rd(e_ea);
        e_acc = 1;
        if (!ent[0] || ent[7:1] != 0) begin e_code = 2; return; end
        e_da = ent[64 +: AW];
        d = rd(e_da);
        e_acc = 2;
        e_desc = d;
        if (d[15:2] != 0 || d[31:24] != 0) begin e_code = 2; return; end
        uv = int'(ent[13:8]);
        e_desc[64 + uv] = 1'b1;
        e_ntf = !d[1] && !d[0];
        if (e_ntf) e_desc[0] = 1'b1;
        e_acc = 3;
        e_vec = d[23:16];
        e_dst = cfg_x2_mode ? d[63:32] : {24'd0, d[47:40]};
    endtask

    // memory, notification and end-pulse responder
    initial begin
        bit acc_pend = 0, have_rsp = 0;
        int dly = 0;
        logic [AW-1:0] a_addr;
        logic a_wr, a_lock;
        logic [127:0] a_wd, rsp_data;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (done) done_cnt++;
            if (fault) begin fault_cnt++; seen_code = fault_code; end
            if (acc_pend) begin
                acc_pend = 0;
                if (acc_cnt == 0) begin first_addr = a_addr; first_lock = a_lock; first_write = a_wr; end
                else if (!a_lock) unlocked_dsc++;
                acc_cnt++;
                if (a_wr) begin mem[a_addr] = a_wd; rsp_data = '0; end
                else rsp_data = rd(a_addr);
                have_rsp = 1;
                dly = $urandom % 3;
                if (a_wr) wr_rsp_cnt = -1;
            end else if (have_rsp) begin
                if (dly == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_rdata = rsp_data;
                    have_rsp = 0;
                    if (wr_rsp_cnt < 0) wr_rsp_cnt = 1;
                end else dly--;
            end
            mem_req_ready = ($urandom % 3) != 0;
            if (mem_req_valid && mem_req_ready) begin
                acc_pend = 1;
                a_addr = mem_req_addr; a_wr = mem_req_write; a_lock = mem_lock; a_wd = mem_req_wdata;
            end
            ntf_ready = ($urandom % 2) != 0;
            if (ntf_valid && ntf_ready) begin
                ntf_cnt++;
                seen_vec = ntf_vector;
                seen_dst = ntf_dest;
                if (wr_rsp_cnt != 1 || mem_lock) ntf_early++;
            end
        end
    end

    task automatic run_cmd(input logic [IW-1:0] idx, input bit spam);
        int cyc = 0;
        predict(idx);
        acc_cnt = 0; unlocked_dsc = 0; ntf_cnt = 0; done_cnt = 0; fault_cnt = 0;
        wr_rsp_cnt = 0; ntf_early = 0; first_lock = 0; first_write = 0; first_addr = '0;
        seen_code = 0;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_index = idx;
        @(negedge clk);
        cmd_valid = spam;
        cmd_index = idx ^ 16'd1;
        while (done_cnt + fault_cnt == 0 && cyc < 400) begin
            @(negedge clk);
            cyc++;
            cmd_valid = spam && (cyc < 3);
        end
        cmd_valid = 1'b0;
        chk(cyc < 400, "watchdog", 128'(cyc), 128'd400);
        repeat (5) @(negedge clk);
        // R11: exactly one end pulse, no stray command from spam
        chk(done_cnt + fault_cnt == 1, "R11 single end", 128'(done_cnt + fault_cnt), 128'd1);
        chk(busy === 1'b0, "R11 idle after end", 128'(busy), 128'd0);
        if (e_code == 0) chk(done_cnt == 1 && fault_cnt == 0, "R11 done", 128'(done_cnt), 128'd1);
        else chk(fault_cnt == 1 && int'(seen_code) == e_code, "R1 R2 R4 R6 fault code",
                 128'(seen_code), 128'(e_code));
        chk(acc_cnt == e_acc, "R1 R2 R4 R6 access count", 128'(acc_cnt), 128'(e_acc));
        if (e_acc >= 1)
            chk(first_addr == e_ea && !first_lock && !first_write, "R3 entry read",
                128'(first_addr), 128'(e_ea));
        if (e_acc >= 2) chk(unlocked_dsc == 0, "R5 locked descriptor", 128'(unlocked_dsc), 128'd0);
        chk(mem_lock === 1'b0, "R5 R6 lock released", 128'(mem_lock), 128'd0);
        if (e_acc >= 2) chk(rd(e_da) == e_desc, "R7 R8 descriptor", rd(e_da), e_desc);
        chk(ntf_cnt == int'(e_ntf), "R8 notify count", 128'(ntf_cnt), 128'(e_ntf));
        if (e_ntf && ntf_cnt == 1) begin
            chk(seen_vec == e_vec, "R9 vector", 128'(seen_vec), 128'(e_vec));
            chk(seen_dst == e_dst, "R9 dest", 128'(seen_dst), 128'(e_dst));
            chk(ntf_early == 0, "R10 after write-back", 128'(ntf_early), 128'd0);
        end
    endtask

    function automatic logic [127:0] mk_ent(input bit v, input logic [6:0] rs, input logic [5:0] uv,
                                            input logic [AW-1:0] da);
        logic [127:0] e = '0;
        e[0] = v; e[7:1] = rs; e[13:8] = uv; e[64 +: AW] = da;
        return e;
    endfunction

    function automatic logic [127:0] mk_dsc(input bit on, input bit sn, input logic [7:0] nv,
                                            input logic [31:0] dst, input logic [63:0] pend);
        logic [127:0] d = '0;
        d[0] = on; d[1] = sn; d[23:16] = nv; d[63:32] = dst; d[127:64] = pend;
        return d;
    endfunction

    localparam logic [AW-1:0] DA0 = 48'h0000_0010_0000;

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !fault && !mem_req_valid && !ntf_valid && !mem_lock,
            "R11 reset state", {busy, done, fault, mem_req_valid, ntf_valid}, 128'd0);

        // directed setup
        cfg_table_base = 48'h0000_0000_1000;
        cfg_table_size = 16'd3;
        for (int i = 0; i < 4; i++)
            mem[cfg_table_base + 48'(i * 16)] = mk_ent(1'b1, 7'd0, 6'(5 + i), DA0 + 48'(i * 64));
        for (int i = 0; i < 4; i++)
            mem[DA0 + 48'(i * 64)] = mk_dsc(1'b0, 1'b0, 8'(8'h40 + i), 32'hA1B2_C3D4, '0);

        cfg_feature_en = 1'b0; run_cmd(16'd0, 0);                 // R1
        cfg_feature_en = 1'b1; cfg_target_en = 1'b0; run_cmd(16'd0, 0); // R1
        cfg_target_en = 1'b1;
        run_cmd(16'd4, 0);                                          // R2 size+1
        cfg_x2_mode = 1'b0; run_cmd(16'd3, 0);                      // R2 idx==size, R9 legacy
        cfg_x2_mode = 1'b1; run_cmd(16'd2, 1);                      // R9 x2, R11 busy spam
        run_cmd(16'd2, 0);                                          // R8 already outstanding
        mem[DA0 + 48'd64] = mk_dsc(1'b0, 1'b1, 8'h77, 32'h1, '0);
        run_cmd(16'd1, 0);                                          // R8 suppressed
        mem[cfg_table_base] = mk_ent(1'b0, 7'd0, 6'd1, DA0);
        run_cmd(16'd0, 0);                                          // R4 invalid
        mem[cfg_table_base] = mk_ent(1'b1, 7'h10, 6'd1, DA0);
        run_cmd(16'd0, 0);                                          // R4 reserved
        mem[cfg_table_base] = mk_ent(1'b1, 7'd0, 6'd63, DA0);
        mem[DA0] = mk_dsc(1'b0, 1'b0, 8'h11, 32'h5, '0) | (128'd1 << 9);
        run_cmd(16'd0, 0);                                          // R6 low reserved
        mem[DA0] = mk_dsc(1'b0, 1'b0, 8'h11, 32'h5, '0) | (128'd1 << 30);
        run_cmd(16'd0, 0);                                          // R6 high reserved
        mem[DA0] = mk_dsc(1'b0, 1'b0, 8'h11, 32'h5, 64'h1);
        run_cmd(16'd0, 0);                                          // R7 top pending bit

        // constrained random
        for (int n = 0; n < 160; n++) begin
            cfg_table_base = 48'(($urandom % 256) << 8);
            cfg_table_size = 16'($urandom % 8);
            cfg_x2_mode = $urandom % 2;
            cfg_feature_en = ($urandom % 16) != 0;
            cfg_target_en = ($urandom % 16) != 0;
            for (int i = 0; i < 8; i++)
                mem[cfg_table_base + 48'(i * 16)] =
                    mk_ent(($urandom % 8) != 0, (($urandom % 8) == 0) ? 7'($urandom) : 7'd0,
                           6'($urandom), DA0 + 48'(($urandom % 4) * 64));
            for (int k = 0; k < 4; k++)
                if (($urandom % 3) == 0) begin
                    mem[DA0 + 48'(k * 64)] =
                        mk_dsc($urandom % 2, ($urandom % 4) == 0, 8'($urandom), $urandom,
                               {$urandom, $urandom});
                    if (($urandom % 8) == 0) mem[DA0 + 48'(k * 64)][24] = 1'b1;
                end
            run_cmd(16'($urandom % 10), 0);                        // R1..R11 random mix
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule